// File: doc/BRIEF.md
# ADC offset compensation calibrator

This block measures the offset of an analog-to-digital converter engine and produces the correction for it. After a start request it takes over the engine-control word. It forces normal operating mode, sets the engine-enable and compensation-sensing bits, and enables channel 0 alone. In compensation-sensing mode the converter input is tied to half the reference, so an ideal engine would read mid-scale. The block then waits out a settling interval and averages a power-of-two number of fresh conversions. It reports the signed difference between the ideal mid-scale code and that average.

The compensating value is held until the next calibration finishes. A copy of it is rescaled for a battery-sense channel, and so is the live sample stream, using the divider-select bit of the control word. When the block is idle, the control word passes through unchanged. The value the system held before calibration therefore returns as soon as the run ends.

Top module: `adc_offset_cal`

## Requirements
- R1: While `busy_o` is low, `eng_ctrl_o` equals `eng_ctrl_i` bit for bit, including right after a calibration completes.
- R2: While `busy_o` is high, `eng_ctrl_o` equals `eng_ctrl_i` with these changes: bit 0 (engine enable) set, bits 3:1 (operating mode) forced to 3'b111 (normal), bit 4 (compensation sensing) set, and bits 31:16 (channel enables) forced to 16'h0001 (channel 0 only).
- R3: Sample strobes that arrive during the first SETTLE_CYCLES clock cycles after an accepted start have no effect on the result.
- R4: After settling, the first sample strobe is discarded, because its conversion may predate the settle. The next 2^AVG_LOG2 strobes (16 by default) are accumulated.
- R5: The compensating value `cv_o` is 2^(DATA_W-1) (512) minus floor(sum / 2^AVG_LOG2), as an 11-bit two's-complement number.
- R6: `busy_o` rises the cycle after start is accepted. `done_o` is high for exactly one cycle, two cycles after the clock edge that takes the last sample; `busy_o` falls in that same cycle. `cv_o` changes only in the cycle where `done_o` is high, and holds its value otherwise.
- R7: A start request while `busy_o` is high is ignored: the run in progress neither restarts nor loses samples.
- R8: `bat_cv_o` is `cv_o` times 3 when `eng_ctrl_i` bit 6 is 1. When bit 6 is 0 it is `cv_o` times 3 divided by 2, truncated toward zero.
- R9: `bat_data_o` is `smp_data_i` times 3 when `eng_ctrl_i` bit 6 is 1. When bit 6 is 0 it is floor(`smp_data_i` times 3 / 2).
- R10: After reset, `busy_o` and `done_o` are 0 and `cv_o` is 0.
- R11: The accumulator is wide enough that 16 full-scale samples (all 1023) give `cv_o` = -511 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a calibration run |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| smp_strobe_i | input | 1 | Engine conversion-complete strobe |
| smp_data_i | input | DATA_W | Conversion result from the engine |
| eng_ctrl_i | input | 32 | Engine-control word requested by the system |
| eng_ctrl_o | output | 32 | Engine-control word applied to the engine |
| cv_o | output | DATA_W+1 | Signed compensating value |
| bat_cv_o | output | DATA_W+3 | Compensating value scaled for the battery channel |
| bat_data_o | output | DATA_W+2 | Live sample scaled for the battery channel |

## Verification
Several checks run on every cycle inside the modules:
- the control-word override while busy, and the pass-through while idle;
- the single-cycle done pulse, and `cv_o` changing only when done is high;
- a start request while busy leaving the block busy;
- the accumulator never decreasing while it collects, staying quiet when no sample is taken, and skipping the first strobe.

Only the bench's scenarios can show the arithmetic result, and the rule that the settle-window and first post-settle strobes leave the average untouched. The bench runs calibrations across a sweep of sample ramps with poisoned discarded samples, and sweeps every input code through the battery scaling.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
   localparam int CTRL_W     = 32;
   localparam int EN_BIT     = 0;
   localparam int MODE_LSB   = 1;
   localparam int MODE_W     = 3;
   localparam logic [MODE_W-1:0] MODE_NORMAL = 3'b111;
   localparam int COMP_BIT   = 4;
   localparam int DIVSEL_BIT = 6;
   localparam int CHAN_LSB   = 16;
   localparam int CHAN_W     = 16;

   typedef enum logic [1:0] {
      CAL_IDLE    = 2'd0,
      CAL_SETTLE  = 2'd1,
      CAL_COLLECT = 2'd2,
      CAL_FINISH  = 2'd3
   } cal_state_e;
endpackage

// File: rtl/adc_cal_settle_timer.sv
module adc_cal_settle_timer #(
   parameter int unsigned CYCLES = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("adc_cal_settle_timer: CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run_i)     cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == LAST);

   // R3: the settle window can only end after the timer has been running
   a_r3_settle_entry: assert property (@(posedge clk) disable iff (!rst_n)
      expired_o |-> ((CYCLES == 1) || $past(run_i)));
endmodule

// File: rtl/adc_cal_accum.sv
module adc_cal_accum #(
   parameter int DATA_W   = 10,
   parameter int AVG_LOG2 = 4,
   parameter int ACC_W    = DATA_W + AVG_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              take_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              last_o,
   output logic [DATA_W-1:0] avg_o
);
   if (ACC_W < DATA_W + AVG_LOG2) begin : g_bad_acc
      $error("adc_cal_accum: ACC_W too narrow for the sample count");
   end
   if (AVG_LOG2 < 1) begin : g_bad_log2
      $error("adc_cal_accum: AVG_LOG2 must be at least 1");
   end

   logic                armed_q;
   logic [AVG_LOG2-1:0] cnt_q;
   logic [ACC_W-1:0]    acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         acc_q   <= '0;
      end else if (clr_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         acc_q   <= '0;
      end else if (take_i) begin
         if (!armed_q) begin
            armed_q <= 1'b1;
         end else begin
            acc_q <= acc_q + ACC_W'(data_i);
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign last_o = take_i && armed_q && (cnt_q == '1);
   assign avg_o  = DATA_W'(acc_q >> AVG_LOG2);

   // R11: a sample never wraps the running sum
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && armed_q && !clr_i) |=> (acc_q >= $past(acc_q)));
   // R3: with no accepted sample, the sum does not move
   a_r3_acc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_i && !clr_i) |=> $stable(acc_q));
   // R4: the first strobe after settling is thrown away
   a_r4_first_discarded: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !armed_q && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/adc_cal_gain_scale.sv
module adc_cal_gain_scale #(
   parameter int IN_W      = 10,
   parameter bit IS_SIGNED = 1'b0
) (
   input  logic [IN_W-1:0] val_i,
   input  logic            third_i,
   output logic [IN_W+1:0] val_o
);
   if (IN_W < 2) begin : g_bad_width
      $error("adc_cal_gain_scale: IN_W must be at least 2");
   end

   if (IS_SIGNED) begin : g_signed
      logic signed [IN_W+1:0] ext, trip, half;
      always_comb begin
         ext  = $signed({{2{val_i[IN_W-1]}}, val_i});
         trip = ext + (ext <<< 1);
         // add one to negatives so the shift truncates toward zero
         half = (trip + $signed({{(IN_W+1){1'b0}}, trip[IN_W+1]})) >>> 1;
         val_o = third_i ? trip : half;
      end
   end else begin : g_unsigned
      logic [IN_W+1:0] ext, trip;
      always_comb begin
         ext   = {2'b00, val_i};
         trip  = ext + (ext << 1);
         val_o = third_i ? trip : (trip >> 1);
      end
   end
endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
   import adc_cal_pkg::*;
#(
   parameter int          DATA_W        = 10,
   parameter int          AVG_LOG2      = 4,
   parameter int          ACC_W         = DATA_W + AVG_LOG2,
   parameter int unsigned SETTLE_CYCLES = 125000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   output logic                     busy_o,
   output logic                     done_o,
   input  logic                     smp_strobe_i,
   input  logic [DATA_W-1:0]        smp_data_i,
   input  logic [CTRL_W-1:0]        eng_ctrl_i,
   output logic [CTRL_W-1:0]        eng_ctrl_o,
   output logic signed [DATA_W:0]   cv_o,
   output logic signed [DATA_W+2:0] bat_cv_o,
   output logic [DATA_W+1:0]        bat_data_o
);
   localparam logic signed [DATA_W:0] MID_CODE = $signed({2'b01, {(DATA_W-1){1'b0}}});

   if (DATA_W < 2) begin : g_bad_data
      $error("adc_offset_cal: DATA_W must be at least 2");
   end
   if (CHAN_LSB + CHAN_W > CTRL_W) begin : g_bad_ctrl
      $error("adc_offset_cal: channel field exceeds control word");
   end

   cal_state_e            state_q, state_d;
   logic                  done_q;
   logic signed [DATA_W:0] cv_q;
   logic                  settle_done, last_smp;
   logic [DATA_W-1:0]     avg;
   logic [DATA_W+1:0]     bat_cv_raw;

   adc_cal_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (state_q == CAL_SETTLE),
      .expired_o (settle_done)
   );

   adc_cal_accum #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2), .ACC_W(ACC_W)) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q == CAL_IDLE),
      .take_i ((state_q == CAL_COLLECT) && smp_strobe_i),
      .data_i (smp_data_i),
      .last_o (last_smp),
      .avg_o  (avg)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CAL_IDLE:    if (start_i)     state_d = CAL_SETTLE;
         CAL_SETTLE:  if (settle_done) state_d = CAL_COLLECT;
         CAL_COLLECT: if (last_smp)    state_d = CAL_FINISH;
         CAL_FINISH:                   state_d = CAL_IDLE;
         default:                      state_d = CAL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CAL_IDLE;
         done_q  <= 1'b0;
         cv_q    <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == CAL_FINISH);
         if (state_q == CAL_FINISH) cv_q <= MID_CODE - $signed({1'b0, avg});
      end
   end

   assign busy_o = (state_q != CAL_IDLE);
   assign done_o = done_q;
   assign cv_o   = cv_q;

   always_comb begin
      eng_ctrl_o = eng_ctrl_i;
      if (busy_o) begin
         eng_ctrl_o[EN_BIT]               = 1'b1;
         eng_ctrl_o[MODE_LSB +: MODE_W]   = MODE_NORMAL;
         eng_ctrl_o[COMP_BIT]             = 1'b1;
         eng_ctrl_o[CHAN_LSB +: CHAN_W]   = CHAN_W'(1);
      end
   end

   adc_cal_gain_scale #(.IN_W(DATA_W + 1), .IS_SIGNED(1'b1)) u_bat_cv (
      .val_i   (cv_q),
      .third_i (eng_ctrl_i[DIVSEL_BIT]),
      .val_o   (bat_cv_raw)
   );
   assign bat_cv_o = $signed(bat_cv_raw);

   adc_cal_gain_scale #(.IN_W(DATA_W), .IS_SIGNED(1'b0)) u_bat_data (
      .val_i   (smp_data_i),
      .third_i (eng_ctrl_i[DIVSEL_BIT]),
      .val_o   (bat_data_o)
   );

   // R2: while busy the engine sees normal mode, compensation, channel 0 only
   a_r2_engine_override: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (eng_ctrl_o[EN_BIT] && eng_ctrl_o[COMP_BIT] &&
                  (eng_ctrl_o[MODE_LSB +: MODE_W] == MODE_NORMAL) &&
                  (eng_ctrl_o[CHAN_LSB +: CHAN_W] == CHAN_W'(1))));
   // R1: idle means the requested control word reaches the engine untouched
   a_r1_ctrl_restore: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (eng_ctrl_o == eng_ctrl_i));
   // R6: done lasts a single cycle and ends a busy period
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));
   // R6: the result only moves when done is raised
   a_r6_cv_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_o != $past(cv_o)) |-> done_o);
   // R7: a start request during a run does not end or restart it
   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && (state_q == CAL_SETTLE || state_q == CAL_COLLECT)) |=> busy_o);
endmodule

// File: tb/test_adc_offset_cal.sv
`timescale 1ns/1ps
module test_adc_offset_cal;
   localparam int DW = 10;
   localparam int AL = 4;
   localparam int ST = 20;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                 rst_n;
   logic                 start_i;
   logic                 busy_o, done_o;
   logic                 smp_strobe_i;
   logic [DW-1:0]        smp_data_i;
   logic [31:0]          eng_ctrl_i, eng_ctrl_o;
   logic signed [DW:0]   cv_o;
   logic signed [DW+2:0] bat_cv_o;
   logic [DW+1:0]        bat_data_o;

   adc_offset_cal #(.DATA_W(DW), .AVG_LOG2(AL), .SETTLE_CYCLES(ST)) i_adc_offset_cal (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
      .smp_strobe_i(smp_strobe_i), .smp_data_i(smp_data_i),
      .eng_ctrl_i(eng_ctrl_i), .eng_ctrl_o(eng_ctrl_o),
      .cv_o(cv_o), .bat_cv_o(bat_cv_o), .bat_data_o(bat_data_o)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ovr(input logic [31:0] c);
      logic [31:0] r;
      r = c;
      r[0] = 1'b1;
      r[3:1] = 3'b111;
      r[4] = 1'b1;
      r[31:16] = 16'h0001;
      return r;
   endfunction

   task automatic run_cal(input int base, input int step, input int poison,
                          input bit divsel, input bit mid_start);
      int s[16];
      int sum;
      int exp_cv, exp_bat;
      logic signed [DW:0] cv_before;
      sum = 0;
      for (int i = 0; i < 16; i++) begin
         s[i] = ((base + i * step) % 1024 + 1024) % 1024;
         sum += s[i];
      end
      exp_cv  = 512 - sum / 16;
      exp_bat = divsel ? exp_cv * 3 : (exp_cv * 3) / 2;
      eng_ctrl_i = 32'h3C5A_9E21 ^ 32'(base * 32'h0101_0007);
      eng_ctrl_i[6] = divsel;
      cv_before = cv_o;

      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(busy_o === 1'b1, "R6 busy after start", busy_o, 1);

      // settle window with poisoned strobes (R3)
      for (int j = 1; j <= ST + 2; j++) begin
         smp_strobe_i = (j % 3 == 0) && (j <= ST - 2);
         smp_data_i   = DW'(poison);
         chk(eng_ctrl_o === ovr(eng_ctrl_i), "R2 override during settle", eng_ctrl_o, ovr(eng_ctrl_i));
         if (j < ST) chk(cv_o === cv_before, "R6 cv held while settling", cv_o, cv_before);
         @(negedge clk);
      end
      smp_strobe_i = 1'b0;

      // first strobe poisoned and discarded (R4), then 16 samples
      for (int i = 0; i <= 16; i++) begin
         smp_strobe_i = 1'b1;
         smp_data_i   = (i == 0) ? DW'(poison) : DW'(s[i-1]);
         @(negedge clk);
         smp_strobe_i = 1'b0;
         smp_data_i   = DW'(poison);
         if (i < 16) begin
            if (mid_start && i == 8) start_i = 1'b1;   // R7
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o && !done_o, "R6 R7 busy held while collecting", busy_o, 1);
            @(negedge clk);
         end
      end
      chk(done_o === 1'b0, "R6 done not early", done_o, 0);
      @(negedge clk);
      chk(done_o === 1'b1, "R6 done timing", done_o, 1);
      chk(busy_o === 1'b0, "R6 busy falls with done", busy_o, 0);
      chk(cv_o == exp_cv, "R3 R4 R5 R11 compensating value", cv_o, exp_cv);
      chk(bat_cv_o == exp_bat, "R8 battery compensating value", bat_cv_o, exp_bat);
      chk(eng_ctrl_o === eng_ctrl_i, "R1 control restored", eng_ctrl_o, eng_ctrl_i);
      @(negedge clk);
      chk(done_o === 1'b0, "R6 done single cycle", done_o, 0);
      for (int k = 0; k < 4; k++) begin
         smp_strobe_i = 1'b1;
         smp_data_i   = DW'(k * 300);
         @(negedge clk);
         chk(cv_o == exp_cv && !done_o, "R6 cv held when idle", cv_o, exp_cv);
      end
      smp_strobe_i = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      start_i = 1'b0;
      smp_strobe_i = 1'b0;
      smp_data_i = '0;
      eng_ctrl_i = 32'h0000_0040;
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b0 && done_o === 1'b0, "R10 reset flags", {busy_o, done_o}, 0);
      chk(cv_o === '0, "R10 reset cv", cv_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o === 1'b0 && cv_o === '0, "R10 state after reset", cv_o, 0);
      eng_ctrl_i = 32'hA5A5_1234;
      #1;
      chk(eng_ctrl_o === eng_ctrl_i, "R1 idle pass-through", eng_ctrl_o, eng_ctrl_i);

      run_cal(512, 0, 0, 1'b1, 1'b0);      // R5 ideal engine
      run_cal(1023, 0, 0, 1'b0, 1'b0);     // R11 full scale
      run_cal(0, 0, 1023, 1'b1, 1'b0);     // R5 zero readings
      run_cal(601, 0, 0, 1'b0, 1'b0);      // R8 odd negative
      run_cal(100, 37, 1023, 1'b0, 1'b1);  // R7 start during run
      for (int b = 0; b < 1024; b += 73) begin
         run_cal(b, (b % 9) - 4, (b < 512) ? 1023 : 0, 1'(b % 2), (b % 3) == 0);
      end

      // R9 battery reading scaling, exhaustive
      for (int d = 0; d < 2; d++) begin
         for (int v = 0; v < 1024; v++) begin
            @(negedge clk);
            eng_ctrl_i[6] = 1'(d);
            smp_data_i = DW'(v);
            #1;
            chk(bat_data_o == ((d == 1) ? v * 3 : (v * 3) / 2), "R9 battery reading",
                bat_data_o, (d == 1) ? v * 3 : (v * 3) / 2);
         end
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule